// File: doc/BRIEF.md
# Serial Flash Program and Erase Sequencer

This block sits on the host side of a four-wire serial flash link. It turns one job request into the full command sequence that the memory needs. A job is either a whole-array erase or a page program of 1 to 256 bytes at a 24-bit start address. For each job the sequencer first sends a stand-alone write-enable command. It then sends the erase opcode, or the program opcode followed by the address and the data. After that it reads the status register over and over until the device reports that its internal self-timed cycle has ended.

Jobs arrive on a valid/ready request port. For a page program, the data bytes arrive on a second valid/ready stream, and the sequencer takes them only when it is about to shift them out. While it waits for a byte it holds the serial clock low and keeps chip select asserted. A job ends with a one-cycle `done` pulse. The `err` flag is valid at that pulse and stays set until the next request is accepted. It reports that the busy bit never cleared within the permitted number of status polls.

Top module: `flash_seq`

## Requirements
- R1: Every job starts with its own chip-select window that carries only the write-enable opcode 0x06, which is exactly 8 serial clock rising edges long. The erase or program window follows only after chip select has gone high.
- R2: An erase job sends opcode 0xC7 most significant bit first in a window of exactly 8 rising edges. Chip select rises with no further clock edge.
- R3: A program job sends opcode 0x02, then address bits 23 down to 0, then exactly `req_len` data bytes (1 to 256), all in one window of 8*(4+`req_len`) rising edges. Every window holds a whole number of bytes.
- R4: When `lsb_first` is 1 at request acceptance, each data byte is sent bit 0 first. When it is 0, bit 7 is sent first. Opcodes and address are always sent bit 7 first.
- R5: The link runs in clock-idle-low mode. `sclk` is low whenever `cs_n` is high, `mosi` changes only while `sclk` is low, and `miso` is sampled at the rising edge.
- R6: Between any two consecutive windows, `cs_n` stays high for at least MIN_GAP system clocks.
- R7: After the erase or program window, the sequencer sends status reads (opcode 0x05 followed by one read byte, 16 rising edges). It repeats them while the last received status bit (bit 0, write in progress) is 1, and pulses `done` with `err`=0 after the first read that returns 0.
- R8: If bit 0 is still 1 after MAX_POLLS status reads, the job ends with `done` and `err`=1, and no further window follows. `err` clears when the next request is accepted.
- R9: `req_ready` is high only while no job is in progress and chip select is high. `done` is a single-cycle pulse.
- R10: `wr_ready` is asserted only inside a program window, when a data byte is due. Bytes are taken in arrival order, one per byte slot, and a stalled stream delays the clock without losing bits.
- R11: After reset, `cs_n`=1, `sclk`=0, `req_ready`=1, `wr_ready`=0, `done`=0 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Job request valid |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_erase | input | 1 | 1 = erase whole array, 0 = page program |
| req_addr | input | 24 | Program start address |
| req_len | input | 9 | Program byte count, 1 to 256 |
| lsb_first | input | 1 | Data bit order for the job, sampled at acceptance |
| wr_valid | input | 1 | Program data byte valid |
| wr_ready | output | 1 | Program data byte taken |
| wr_data | input | 8 | Program data byte |
| done | output | 1 | One-cycle job completion pulse |
| err | output | 1 | Busy bit did not clear within the poll limit |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The assertions check the link-level rules on every cycle: the clock parks low while deselected, `mosi` moves only in the low phase, every window closes on a byte boundary, and the deselect gap is held. They also check that the handshake outputs stay inside their allowed phases and that `done` lasts one cycle. The opcode and address content, the data values and their bit order, the number of status polls against the device's busy time, and the timeout outcome can only be shown by the bench. It does this with a behavioural flash model that decodes each window and answers status reads with a configurable busy duration.

// File: rtl/flash_seq_pkg.sv
// Shared constants and types for the serial flash sequencer.
// Assumes a device that takes commands bit 7 first and reports busy in status bit 0.
package flash_seq_pkg;
    localparam logic [7:0] OP_WR_ENABLE = 8'h06;
    localparam logic [7:0] OP_STATUS    = 8'h05;
    localparam logic [7:0] OP_PAGE_PROG = 8'h02;
    localparam logic [7:0] OP_ERASE_ALL = 8'hC7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_XFER,
        ST_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_WREN,
        CMD_MAIN,
        CMD_POLL
    } cmd_e;
endpackage

// File: rtl/flash_seq_shifter.sv
// Byte shifter for a clock-idle-low serial link.
// Shifts one byte per start pulse. The serial clock is clk divided by DIV (DIV even, >= 2).
// The output bit changes only while sclk is low, and the input is sampled at each rising edge.
// rx_bit holds the last sampled input bit, which is bit 0 of a byte received bit 7 first.
// Assumes start arrives only while the previous byte has finished (done seen).
module flash_seq_shifter #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       lsb_first,
    output logic       done,
    output logic       rx_bit,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic          busy;
    logic [CW-1:0] cnt;
    logic [2:0]    nbit;
    logic [7:0]    sh;
    logic          lsb_q;

    assign mosi = lsb_q ? sh[0] : sh[7];

    // Load a byte, time the half periods, sample at rise, advance at fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            cnt    <= '0;
            nbit   <= '0;
            sh     <= '0;
            lsb_q  <= 1'b0;
            sclk   <= 1'b0;
            rx_bit <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    sh    <= tx_byte;
                    lsb_q <= lsb_first;
                    cnt   <= '0;
                    nbit  <= '0;
                end
            end else if (cnt == CW'(HALF - 1)) begin
                cnt <= '0;
                if (!sclk) begin
                    sclk   <= 1'b1;
                    rx_bit <= miso;
                end else begin
                    sclk <= 1'b0;
                    if (nbit == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        nbit <= nbit + 3'd1;
                        sh   <= lsb_q ? {1'b0, sh[7:1]} : {sh[6:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_seq_ctrl.sv
// Job sequencer for the serial flash link.
// Runs three command windows in order: write enable, then erase or program, then repeated status reads.
// Holds chip select high for MIN_GAP clocks between windows.
// Ends after MAX_POLLS status reads if the busy bit stays set.
// Assumes req_len is 1 to 256 and MIN_GAP >= 1.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int MIN_GAP   = 4,
    parameter int MAX_POLLS = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_erase,
    input  logic [23:0] req_addr,
    input  logic [8:0]  req_len,
    input  logic        lsb_first,
    input  logic        wr_valid,
    output logic        wr_ready,
    input  logic [7:0]  wr_data,
    output logic        done,
    output logic        err,
    output logic        cs_n,
    output logic        sh_start,
    output logic [7:0]  sh_tx,
    output logic        sh_lsb,
    input  logic        sh_done,
    input  logic        sh_wip
);
    localparam int GW  = $clog2(MIN_GAP + 1);
    localparam int PCW = $clog2(MAX_POLLS + 1);

    seq_state_e     st;
    cmd_e           cur;
    logic           erase_q;
    logic           lsb_q;
    logic [23:0]    addr_q;
    logic [8:0]     len_q;
    logic [9:0]     pos;
    logic           issue;
    logic [GW-1:0]  gcnt;
    logic [PCW-1:0] pcnt;
    logic [9:0]     last_pos;
    logic           is_data;
    logic           can_issue;
    logic [7:0]     byte_sel;

    // Position of the final byte in the current window.
    always_comb begin
        unique case (cur)
            CMD_WREN: last_pos = 10'd0;
            CMD_POLL: last_pos = 10'd1;
            default:  last_pos = erase_q ? 10'd0 : 10'd3 + {1'b0, len_q};
        endcase
    end

    // Pick the byte for the current window position.
    always_comb begin
        byte_sel = 8'h00;
        unique case (cur)
            CMD_WREN: byte_sel = OP_WR_ENABLE;
            CMD_POLL: byte_sel = (pos == 10'd0) ? OP_STATUS : 8'h00;
            default: begin
                if (pos == 10'd0)      byte_sel = erase_q ? OP_ERASE_ALL : OP_PAGE_PROG;
                else if (pos == 10'd1) byte_sel = addr_q[23:16];
                else if (pos == 10'd2) byte_sel = addr_q[15:8];
                else if (pos == 10'd3) byte_sel = addr_q[7:0];
                else                   byte_sel = wr_data;
            end
        endcase
    end

    assign is_data   = (cur == CMD_MAIN) && !erase_q && (pos >= 10'd4);
    assign can_issue = issue && (!is_data || wr_valid);
    assign wr_ready  = (st == ST_XFER) && issue && is_data;
    assign req_ready = (st == ST_IDLE);

    // Job state machine: gap timing, byte issue, window close and poll decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cur      <= CMD_WREN;
            erase_q  <= 1'b0;
            lsb_q    <= 1'b0;
            addr_q   <= '0;
            len_q    <= '0;
            pos      <= '0;
            issue    <= 1'b0;
            gcnt     <= '0;
            pcnt     <= '0;
            cs_n     <= 1'b1;
            sh_start <= 1'b0;
            sh_tx    <= '0;
            sh_lsb   <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            sh_start <= 1'b0;
            done     <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        erase_q <= req_erase;
                        lsb_q   <= lsb_first;
                        addr_q  <= req_addr;
                        len_q   <= req_len;
                        err     <= 1'b0;
                        pcnt    <= '0;
                        gcnt    <= '0;
                        cur     <= CMD_WREN;
                        st      <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gcnt == GW'(MIN_GAP - 1)) begin
                        cs_n  <= 1'b0;
                        pos   <= '0;
                        issue <= 1'b1;
                        gcnt  <= '0;
                        st    <= ST_XFER;
                    end else begin
                        gcnt <= gcnt + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (can_issue) begin
                        sh_start <= 1'b1;
                        sh_tx    <= byte_sel;
                        sh_lsb   <= is_data && lsb_q;
                        issue    <= 1'b0;
                    end else if (sh_done) begin
                        if (pos == last_pos) begin
                            cs_n <= 1'b1;
                            gcnt <= '0;
                            unique case (cur)
                                CMD_WREN: begin
                                    cur <= CMD_MAIN;
                                    st  <= ST_GAP;
                                end
                                CMD_MAIN: begin
                                    cur <= CMD_POLL;
                                    st  <= ST_GAP;
                                end
                                default: begin
                                    if (!sh_wip) begin
                                        st <= ST_FIN;
                                    end else if (pcnt == PCW'(MAX_POLLS - 1)) begin
                                        err <= 1'b1;
                                        st  <= ST_FIN;
                                    end else begin
                                        pcnt <= pcnt + 1'b1;
                                        st   <= ST_GAP;
                                    end
                                end
                            endcase
                        end else begin
                            pos   <= pos + 10'd1;
                            issue <= 1'b1;
                        end
                    end
                end
                default: begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/flash_seq.sv
// Top level of the serial flash program and erase sequencer.
// Connects the job sequencer to the byte shifter that drives the four-wire link.
// Assumes DIV is even and >= 2, MIN_GAP >= 1 and MAX_POLLS >= 1.
module flash_seq #(
    parameter int DIV       = 4,
    parameter int MIN_GAP   = 4,
    parameter int MAX_POLLS = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_erase,
    input  logic [23:0] req_addr,
    input  logic [8:0]  req_len,
    input  logic        lsb_first,
    input  logic        wr_valid,
    output logic        wr_ready,
    input  logic [7:0]  wr_data,
    output logic        done,
    output logic        err,
    output logic        cs_n,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso
);
    logic       sh_start;
    logic [7:0] sh_tx;
    logic       sh_lsb;
    logic       sh_done;
    logic       sh_wip;

    flash_seq_ctrl #(
        .MIN_GAP   (MIN_GAP),
        .MAX_POLLS (MAX_POLLS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_erase (req_erase),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .lsb_first (lsb_first),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_data   (wr_data),
        .done      (done),
        .err       (err),
        .cs_n      (cs_n),
        .sh_start  (sh_start),
        .sh_tx     (sh_tx),
        .sh_lsb    (sh_lsb),
        .sh_done   (sh_done),
        .sh_wip    (sh_wip)
    );

    flash_seq_shifter #(
        .DIV (DIV)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sh_start),
        .tx_byte   (sh_tx),
        .lsb_first (sh_lsb),
        .done      (sh_done),
        .rx_bit    (sh_wip),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso)
    );
endmodule

// File: rtl/flash_seq_checker.sv
// Protocol checker bound to flash_seq. It watches only the top-level ports.
// It counts serial clock rises per window and high cycles of chip select.
module flash_seq_checker #(
    parameter int MIN_GAP = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic wr_ready,
    input logic done,
    input logic cs_n,
    input logic sclk,
    input logic mosi
);
    logic        sclk_q;
    logic [11:0] rises;
    logic [15:0] hi_cnt;

    // Count rising serial clock edges inside a window and chip-select high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            rises  <= '0;
            hi_cnt <= '0;
        end else begin
            sclk_q <= sclk;
            if (cs_n)              rises <= '0;
            else if (sclk && !sclk_q) rises <= rises + 12'd1;
            if (!cs_n)             hi_cnt <= '0;
            else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
        end
    end

    AST_WHOLE_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (rises[2:0] == 3'd0) && (rises != 12'd0)); // R3
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R5
    AST_MOSI_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> !sclk); // R5
    AST_DESELECT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= 16'(MIN_GAP))); // R6
    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n); // R7
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n && !wr_ready); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DATA_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !cs_n); // R10
endmodule

bind flash_seq flash_seq_checker #(.MIN_GAP(MIN_GAP)) u_chk (.*);

// File: tb/flash_seq_bench.sv
`timescale 1ns/1ps
module flash_seq_bench;
    localparam int DIV       = 4;
    localparam int MIN_GAP   = 3;
    localparam int MAX_POLLS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_erase = 1'b0;
    logic [23:0] req_addr = '0;
    logic [8:0]  req_len = 9'd1;
    logic        lsb_first = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        done;
    logic        err;
    logic        cs_n;
    logic        sclk;
    logic        mosi;
    logic        miso;

    always #2.5 clk = ~clk;

    flash_seq #(.DIV(DIV), .MIN_GAP(MIN_GAP), .MAX_POLLS(MAX_POLLS)) u_flash_seq (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // ---------------- flash device model ----------------
    int         bits = 0;
    logic [7:0] shreg = '0;
    logic [7:0] cur_bytes [0:263];
    logic [7:0] main_bytes [0:263];
    int         main_bits = 0;
    int         wcount = 0;
    logic [7:0] wop [0:63];
    int         wbits [0:63];
    int         busy_left = 0;
    int         cfg_busy = 0;
    logic [7:0] stat_byte;

    assign stat_byte = {6'd0, 1'b1, busy_left != 0};
    assign miso = (!cs_n && bits >= 8 && bits < 16 && cur_bytes[0] == 8'h05)
                  ? stat_byte[3'(7 - (bits % 8))] : 1'b0;

    always @(negedge cs_n) bits = 0;

    always @(posedge sclk) begin
        if (!cs_n) begin
            shreg = {shreg[6:0], mosi};
            bits++;
            if (bits % 8 == 0 && bits / 8 <= 264) cur_bytes[bits/8 - 1] = shreg;
        end
    end

    always @(posedge cs_n) begin
        if (rst_n) begin
            if (wcount < 64) begin
                wop[wcount]   = cur_bytes[0];
                wbits[wcount] = bits;
            end
            wcount++;
            if (bits >= 8 && (cur_bytes[0] == 8'h02 || cur_bytes[0] == 8'hC7)) begin
                busy_left = cfg_busy;
                main_bits = bits;
                for (int i = 0; i < 264; i++) main_bytes[i] = cur_bytes[i];
            end else if (cur_bytes[0] == 8'h05 && bits == 16 && busy_left > 0) begin
                busy_left--;
            end
        end
    end

    // ---------------- handshake and gap observers ----------------
    int req_acc = 0, wr_acc = 0, done_cnt = 0, hi = 0, min_gap_seen = 100000;
    logic err_at_done = 1'b0;
    always @(posedge clk) begin
        if (rst_n) begin
            if (req_valid && req_ready) req_acc++;
            if (wr_valid && wr_ready)   wr_acc++;
            if (done) begin
                done_cnt++;
                err_at_done = err;
            end
            if (cs_n) hi++;
            else begin
                if (hi > 0 && hi < min_gap_seen) min_gap_seen = hi;
                hi = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
    endfunction

    logic [7:0] data [0:255];

    task automatic run_job(input bit erase, input logic [23:0] addr, input int len,
                           input bit lsb, input int busy, input bit timeout);
        int r0, w0, d0, nfeed, polls, bad, ready_bad, w_after;
        for (int i = 0; i < len; i++) data[i] = 8'($urandom);
        cfg_busy = busy;
        wcount = 0;
        min_gap_seen = 100000;
        r0 = req_acc; w0 = wr_acc; d0 = done_cnt;
        nfeed = erase ? 0 : len;
        ready_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_erase = erase; req_addr = addr;
        req_len = 9'(len); lsb_first = lsb;
        while (req_acc == r0) @(negedge clk);
        req_valid = 1'b0;
        lsb_first = ~lsb;  // must not matter after acceptance (R4)
        while (done_cnt == d0) begin
            int idx;
            idx = wr_acc - w0;
            if (req_ready && !done) ready_bad++;
            if (idx < nfeed && ($urandom % 4) != 0) begin
                wr_valid = 1'b1;
                wr_data = data[idx];
            end else begin
                wr_valid = 1'b0;
                wr_data = 8'($urandom);
            end
            @(negedge clk);
        end
        wr_valid = 1'b0;
        w_after = wcount;
        repeat (60) @(negedge clk);
        polls = timeout ? MAX_POLLS : busy + 1;
        chk(ready_bad == 0, "R9 req_ready during job", ready_bad, 0);
        chk(done_cnt == d0 + 1, "R9 single done", done_cnt - d0, 1);
        chk(wcount == 2 + polls, "R7 window count", wcount, 2 + polls);
        chk(wcount == w_after, "R8 no window after done", wcount, w_after);
        chk(wop[0] == 8'h06 && wbits[0] == 8, "R1 write-enable window",
            {wop[0], 16'(wbits[0])}, {8'h06, 16'd8});
        if (erase) begin
            chk(wop[1] == 8'hC7 && wbits[1] == 8, "R2 erase window",
                {wop[1], 16'(wbits[1])}, {8'hC7, 16'd8});
        end else begin
            chk(wop[1] == 8'h02 && main_bits == 8 * (4 + len), "R3 program window",
                {wop[1], 16'(main_bits)}, {8'h02, 16'(8 * (4 + len))});
            chk({main_bytes[1], main_bytes[2], main_bytes[3]} == addr, "R3 address",
                {main_bytes[1], main_bytes[2], main_bytes[3]}, addr);
            bad = 0;
            for (int i = 0; i < len; i++)
                if (main_bytes[4+i] != (lsb ? rev8(data[i]) : data[i])) bad++;
            chk(bad == 0, lsb ? "R4 data lsb-first" : "R4 data msb-first", bad, 0);
            chk(wr_acc - w0 == len, "R10 bytes taken", wr_acc - w0, len);
        end
        bad = 0;
        for (int i = 2; i < wcount && i < 64; i++)
            if (wop[i] != 8'h05 || wbits[i] != 16) bad++;
        chk(bad == 0, "R7 status read windows", bad, 0);
        chk(err_at_done == timeout, timeout ? "R8 timeout err" : "R7 err clear",
            err_at_done, timeout);
        chk(min_gap_seen >= MIN_GAP, "R6 deselect gap", min_gap_seen, MIN_GAP);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !sclk && req_ready && !wr_ready && !done && !err, "R11 reset state",
            {cs_n, sclk, req_ready, wr_ready, done, err}, 6'b101000);
        run_job(1'b1, 24'h000000, 1, 1'b0, 0, 1'b0);       // erase, ready at first poll
        run_job(1'b1, 24'h000000, 1, 1'b0, 3, 1'b0);       // erase, busy for three polls
        run_job(1'b0, 24'h123456, 1, 1'b0, 1, 1'b0);       // single byte program
        run_job(1'b0, 24'hFFFFFF, 2, 1'b1, 0, 1'b0);       // top address, lsb-first
        run_job(1'b0, 24'hA5C300, 256, 1'b1, 2, 1'b0);     // full page, lsb-first
        run_job(1'b0, 24'h000100, 5, 1'b0, MAX_POLLS + 4, 1'b1); // poll timeout (R8)
        run_job(1'b0, 24'h0000FF, 3, 1'b0, 0, 1'b0);       // err clears on next job
        for (int k = 0; k < 4; k++) begin
            int ln;
            ln = 1 + int'($urandom % 40);
            run_job(1'($urandom % 2), 24'($urandom), ln, 1'($urandom % 2),
                    int'($urandom % 4), 1'b0);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule